// File: doc/BRIEF.md
# Type-0 Configuration Space with Base-Address Size Masking

This block holds the 256-byte configuration header and register space of a single endpoint function. An address/data front end hands it dword-wide write accesses with per-byte enables and dword read requests. On a write, the block stores only the bytes that the header layout allows software to change. It forces the self-test byte back to zero. It then takes one more cycle to trim every touched base-address register to the size and type its parameters declare.

The six base-address registers are set by parameters. Each one is unused, an I/O window with a port count, or a 32-bit memory window with a count of 4 KiB pages. Their size masks and reset images are worked out from those parameters at elaboration. The command byte drives two enable pins. Each completed write produces a one-cycle report with the first byte offset and the byte count. It also pulses a flag for the base-address register it touched. The expansion-ROM flag stays set until an acknowledge arrives.

Both data paths use valid/ready. A write is taken when `wr_valid` and `wr_ready` are both high. `wr_ready` drops for the trimming cycle that follows. A read request is taken only when no write is offered, no trimming cycle is running, and the single response register is empty or being drained. A response stays unchanged while `rsp_ready` is low.

Top module: `cfgsp_top`

## Requirements
- R1: After reset the space reads as follows. Bytes 0..1 hold the vendor ID and bytes 2..3 the device ID. Byte 8 holds the revision and bytes 9..11 the class code. Byte 0x0E (header type) is 0 and byte 0x3D holds the interrupt pin. BAR i sits at byte 0x10+4*i and its reset value depends on its kind. An I/O BAR resets to (base AND mask) OR 1. A memory BAR resets to base AND mask, with bit 3 also set when that BAR is marked prefetchable. An unused BAR resets to 0. Every other byte is 0.
- R2: Writes to bytes 0x00–0x03, 0x08–0x0B, 0x0E and 0x3D have no effect. All other enabled bytes take the written data.
- R3: In the cycle after a write to a BAR's dword, that dword is ANDed with its mask. An I/O BAR's mask is NOT(ports−1) with bit 0 set. A memory BAR's mask is NOT((pages<<12)−1) with bits 3..0 set.
- R4: An unused BAR reads as zero after any write.
- R5: `io_en` equals bit 0 and `mem_en` equals bit 1 of command byte 0x04.
- R6: Any write that enables byte 0x0F leaves that byte reading 0.
- R7: A write with any byte enabled in dword 0x30–0x33 sets `rom_upd` in the trimming cycle. The flag holds until `rom_ack` is seen, and a new set takes priority over an acknowledge in the same cycle.
- R8: In the cycle after a write is accepted, `bar_upd[i]` pulses for exactly one cycle if that write enabled any byte of BAR i. At most one bit is ever set.
- R9: `cfg_upd` pulses once in the cycle after each accepted write. `cfg_upd_off` gives the lowest enabled byte offset (dword*4 + lowest set lane, or dword*4 when no lane is set). `cfg_upd_len` gives the number of enabled lanes.
- R10: `wr_ready` is low for exactly the one cycle after an accepted write. When a write and a read are offered together, the write goes first.
- R11: A read request is taken only when no write is offered, `wr_ready` is high, and the response register is empty or being drained. The response carries byte dword*4 in bits 7:0 up to byte dword*4+3 in bits 31:24. It holds steady while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken |
| wr_dw | input | 6 | Dword index of the write |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data, lane k in bits 8k+7..8k |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request can be taken |
| rd_dw | input | 6 | Dword index of the read |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read response dword |
| io_en | output | 1 | Command byte bit 0 |
| mem_en | output | 1 | Command byte bit 1 |
| bar_upd | output | 6 | Per-BAR update pulse |
| rom_upd | output | 1 | Sticky expansion-ROM update flag |
| rom_ack | input | 1 | Clears `rom_upd` |
| cfg_upd | output | 1 | One pulse per completed write |
| cfg_upd_off | output | 8 | First enabled byte offset of that write |
| cfg_upd_len | output | 3 | Enabled byte count of that write |

## Verification
The hardest case to reach is a read that competes with a write. The read must wait through both the accepting cycle and the trimming cycle, and then return the value after the mask, never the raw written bytes. The bench starts a write and a read to the same BAR in the same cycle. It also sends partial-lane writes into a memory BAR, so that the bits which survive depend on both the lane and the mask. A response held under back-pressure is kept waiting for several cycles while a second request is offered. Every cycle the outputs are compared against a behavioural model.

// File: rtl/cfgsp_pkg.sv
`timescale 1ns/1ps
package cfgsp_pkg;
  localparam int NUM_BARS = 6;
  localparam int BAR_DW0  = 4;    // first BAR dword (byte 0x10)
  localparam int ROM_DW   = 12;   // expansion ROM dword (byte 0x30)
  localparam int CMD_OFF  = 4;
  localparam int BIST_OFF = 15;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_IO    = 2'd1,
    KIND_MEM32 = 2'd2
  } bar_kind_e;

  // Bytes software may never change in a type-0 header.
  function automatic logic is_fixed_byte(input logic [7:0] off);
    return off inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h08, 8'h09,
                       8'h0A, 8'h0B, 8'h0E, 8'h3D};
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] kind,
                                            input logic [31:0] size);
    logic [31:0] m;
    m = 32'h0;
    if (kind == KIND_IO)         m = ~(size - 32'd1) | 32'h1;
    else if (kind == KIND_MEM32) m = ~((size << 12) - 32'd1) | 32'hF;
    return m;
  endfunction

  function automatic logic [31:0] bar_image(input logic [1:0] kind,
                                            input logic [31:0] size,
                                            input logic [31:0] base,
                                            input logic pref);
    logic [31:0] v;
    v = base & size_mask(kind, size);
    if (kind == KIND_IO)         v = v | 32'h1;
    else if (kind == KIND_MEM32) v = v | (pref ? 32'h8 : 32'h0);
    else                         v = 32'h0;
    return v;
  endfunction
endpackage

// File: rtl/cfgsp_bar_table.sv
`timescale 1ns/1ps
module cfgsp_bar_table #(
  parameter int NB = 6,
  parameter logic [2*NB-1:0]  KINDS = '0,
  parameter logic [32*NB-1:0] SIZES = '0,
  parameter logic [32*NB-1:0] BASES = '0,
  parameter logic [NB-1:0]    PREF  = '0
) (
  output logic [32*NB-1:0] masks,
  output logic [32*NB-1:0] images
);
  for (genvar i = 0; i < NB; i++) begin : g_bar
    assign masks[32*i +: 32]  = cfgsp_pkg::size_mask(KINDS[2*i +: 2], SIZES[32*i +: 32]);
    assign images[32*i +: 32] = cfgsp_pkg::bar_image(KINDS[2*i +: 2], SIZES[32*i +: 32],
                                                      BASES[32*i +: 32], PREF[i]);
  end
endmodule

// File: rtl/cfgsp_ctrl.sv
`timescale 1ns/1ps
module cfgsp_ctrl #(
  parameter int DW_W = 6,
  parameter int NB   = 6,
  localparam int OFF_W = DW_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [DW_W-1:0]  wr_dw,
  input  logic [3:0]       wr_be,
  output logic             wr_ready,
  output logic             wr_take,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic             rd_take,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic             fix,
  output logic [NB-1:0]    fix_bars,
  input  logic             rom_ack,
  output logic             rom_upd,
  output logic             cfg_upd,
  output logic [OFF_W-1:0] cfg_off,
  output logic [2:0]       cfg_len
);
  logic          phase;
  logic [NB-1:0] pend_bar, hit;
  logic          pend_rom, rom_hit;
  logic [1:0]    lead;

  assign wr_ready = !phase;
  assign wr_take  = wr_valid && !phase;
  assign rd_ready = !phase && !wr_valid && (!rsp_valid || rsp_ready);
  assign rd_take  = rd_valid && rd_ready;

  always_comb begin
    lead = 2'd0;
    for (int k = 3; k >= 0; k--) if (wr_be[k]) lead = 2'(k);
    hit = '0;
    for (int i = 0; i < NB; i++)
      if (int'(wr_dw) == cfgsp_pkg::BAR_DW0 + i) hit[i] = |wr_be;
    rom_hit = (int'(wr_dw) == cfgsp_pkg::ROM_DW) && (|wr_be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      pend_bar  <= '0;
      pend_rom  <= 1'b0;
      cfg_off   <= '0;
      cfg_len   <= '0;
      rom_upd   <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      phase <= wr_take;
      if (wr_take) begin
        pend_bar <= hit;
        pend_rom <= rom_hit;
        cfg_off  <= {wr_dw, lead};
        cfg_len  <= 3'($countones(wr_be));
      end
      if (phase && pend_rom) rom_upd <= 1'b1;
      else if (rom_ack)      rom_upd <= 1'b0;
      if (rd_take)        rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
    end
  end

  assign fix      = phase;
  assign fix_bars = phase ? pend_bar : '0;
  assign cfg_upd  = phase;
endmodule

// File: rtl/cfgsp_store.sv
`timescale 1ns/1ps
module cfgsp_store #(
  parameter int DW_W = 6,
  parameter int NB   = 6,
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [7:0]  REVISION   = 8'h0,
  parameter logic [23:0] CLASS_CODE = 24'h0,
  parameter logic [7:0]  INT_PIN    = 8'h0,
  localparam int OFF_W = DW_W + 2,
  localparam int BYTES = 1 << OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [DW_W-1:0]  wr_dw,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             fix,
  input  logic [NB-1:0]    fix_bars,
  input  logic [32*NB-1:0] bar_masks,
  input  logic [32*NB-1:0] bar_images,
  input  logic             rd_take,
  input  logic [DW_W-1:0]  rd_dw,
  output logic [31:0]      rsp_data,
  output logic             io_en,
  output logic             mem_en
);
  logic [7:0] cfg [BYTES];

  function automatic logic [7:0] boot_byte(input int a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      8:  v = REVISION;
      9:  v = CLASS_CODE[7:0];
      10: v = CLASS_CODE[15:8];
      11: v = CLASS_CODE[23:16];
      61: v = INT_PIN;
      default: if (a >= 16 && a < 16 + 4*NB) v = bar_images[8*(a-16) +: 8];
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < BYTES; a++) cfg[a] <= boot_byte(a);
      rsp_data <= '0;
    end else begin
      if (wr_take)
        for (int k = 0; k < 4; k++)
          if (wr_be[k] && !cfgsp_pkg::is_fixed_byte(8'({wr_dw, 2'(k)})))
            cfg[{wr_dw, 2'(k)}] <= ({wr_dw, 2'(k)} == OFF_W'(cfgsp_pkg::BIST_OFF))
                                   ? 8'h00 : wr_data[8*k +: 8];
      if (fix)
        for (int i = 0; i < NB; i++)
          for (int k = 0; k < 4; k++)
            if (fix_bars[i])
              cfg[OFF_W'(16 + 4*i + k)] <= cfg[OFF_W'(16 + 4*i + k)] & bar_masks[32*i + 8*k +: 8];
      if (rd_take)
        rsp_data <= {cfg[{rd_dw, 2'd3}], cfg[{rd_dw, 2'd2}],
                     cfg[{rd_dw, 2'd1}], cfg[{rd_dw, 2'd0}]};
    end
  end

  assign io_en  = cfg[OFF_W'(cfgsp_pkg::CMD_OFF)][0];
  assign mem_en = cfg[OFF_W'(cfgsp_pkg::CMD_OFF)][1];
endmodule

// File: rtl/cfgsp_top.sv
`timescale 1ns/1ps
module cfgsp_top #(
  parameter int DW_W = 6,
  parameter int NB   = cfgsp_pkg::NUM_BARS,
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A55,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h060000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [2*NB-1:0]  BAR_KINDS = 12'b00_00_00_10_10_01,
  parameter logic [32*NB-1:0] BAR_SIZES = {32'd0, 32'd0, 32'd0, 32'd1, 32'd4, 32'd32},
  parameter logic [32*NB-1:0] BAR_BASES = {32'd0, 32'd0, 32'd0, 32'hFEC0_0000,
                                           32'hFEB0_0000, 32'h0000_C000},
  parameter logic [NB-1:0]    BAR_PREF  = 6'b000010,
  localparam int OFF_W = DW_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW_W-1:0]  wr_dw,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [DW_W-1:0]  rd_dw,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data,
  output logic             io_en,
  output logic             mem_en,
  output logic [NB-1:0]    bar_upd,
  output logic             rom_upd,
  input  logic             rom_ack,
  output logic             cfg_upd,
  output logic [OFF_W-1:0] cfg_upd_off,
  output logic [2:0]       cfg_upd_len
);
  logic [32*NB-1:0] bar_masks, bar_images;
  logic wr_take, rd_take, fix;

  cfgsp_bar_table #(.NB(NB), .KINDS(BAR_KINDS), .SIZES(BAR_SIZES),
                    .BASES(BAR_BASES), .PREF(BAR_PREF)) u_bars (
    .masks(bar_masks), .images(bar_images));

  cfgsp_ctrl #(.DW_W(DW_W), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_dw(wr_dw), .wr_be(wr_be),
    .wr_ready(wr_ready), .wr_take(wr_take), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_take(rd_take), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .fix(fix),
    .fix_bars(bar_upd), .rom_ack(rom_ack), .rom_upd(rom_upd), .cfg_upd(cfg_upd),
    .cfg_off(cfg_upd_off), .cfg_len(cfg_upd_len));

  cfgsp_store #(.DW_W(DW_W), .NB(NB), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
                .REVISION(REVISION), .CLASS_CODE(CLASS_CODE), .INT_PIN(INT_PIN)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .wr_dw(wr_dw), .wr_be(wr_be),
    .wr_data(wr_data), .fix(fix), .fix_bars(bar_upd), .bar_masks(bar_masks),
    .bar_images(bar_images), .rd_take(rd_take), .rd_dw(rd_dw), .rsp_data(rsp_data),
    .io_en(io_en), .mem_en(mem_en));
endmodule

// File: rtl/cfgsp_checker.sv
`timescale 1ns/1ps
module cfgsp_checker #(parameter int NB = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_data,
  input logic [NB-1:0] bar_upd,
  input logic          cfg_upd,
  input logic          rom_upd,
  input logic          rom_ack
);
  assert_wr_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_ready && cfg_upd));
  assert_upd_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |-> $past(wr_valid && wr_ready));
  assert_bar_pulse_in_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|bar_upd) |-> cfg_upd);
  assert_bar_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_upd));
  assert_rom_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_upd && !rom_ack) |=> rom_upd);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  assert_no_read_in_fix_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !rd_ready);
endmodule

bind cfgsp_top cfgsp_checker #(.NB(NB)) u_cfgsp_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .bar_upd(bar_upd), .cfg_upd(cfg_upd),
  .rom_upd(rom_upd), .rom_ack(rom_ack));

// File: tb/test_cfgsp_top.sv
`timescale 1ns/1ps
module test_cfgsp_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, rd_valid = 0, rsp_ready = 1, rom_ack = 0;
  logic [5:0] wr_dw = 0, rd_dw = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] wr_data = 0;
  logic wr_ready, rd_ready, rsp_valid, io_en, mem_en, rom_upd, cfg_upd;
  logic [31:0] rsp_data;
  logic [5:0] bar_upd;
  logic [7:0] cfg_upd_off;
  logic [2:0] cfg_upd_len;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  cfgsp_top i_cfgsp_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dw(wr_dw),
    .wr_be(wr_be), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_dw(rd_dw), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .io_en(io_en), .mem_en(mem_en), .bar_upd(bar_upd), .rom_upd(rom_upd),
    .rom_ack(rom_ack), .cfg_upd(cfg_upd), .cfg_upd_off(cfg_upd_off),
    .cfg_upd_len(cfg_upd_len));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_cfg [256];
  bit m_phase, m_rom, m_rsp_v, m_pend_rom;
  int m_pend_bar, m_off, m_len;
  logic [31:0] m_rsp_d;
  bit m_wacc, m_racc;

  function automatic logic [31:0] m_mask(input int i);
    case (i)
      0: return 32'hFFFF_FFE1;   // I/O, 32 ports
      1: return 32'hFFFF_C00F;   // memory, 4 pages
      2: return 32'hFFFF_F00F;   // memory, 1 page
      default: return 32'h0;     // unused
    endcase
  endfunction

  function automatic bit m_locked(input int o);
    return (o <= 3) || (o >= 8 && o <= 11) || o == 14 || o == 61;
  endfunction

  task automatic m_reset();
    for (int a = 0; a < 256; a++) m_cfg[a] = 8'h00;
    {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]} = 32'h0A55_C0DE;
    {m_cfg[11], m_cfg[10], m_cfg[9], m_cfg[8]} = 32'h0600_0002;
    m_cfg[61] = 8'h01;
    {m_cfg[19], m_cfg[18], m_cfg[17], m_cfg[16]} = 32'h0000_C001;
    {m_cfg[23], m_cfg[22], m_cfg[21], m_cfg[20]} = 32'hFEB0_0008;
    {m_cfg[27], m_cfg[26], m_cfg[25], m_cfg[24]} = 32'hFEC0_0000;
    m_phase = 0; m_rom = 0; m_rsp_v = 0; m_pend_rom = 0; m_pend_bar = -1;
    m_off = 0; m_len = 0; m_rsp_d = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      m_wacc = wr_valid && !m_phase;
      m_racc = rd_valid && !m_phase && !wr_valid && (!m_rsp_v || rsp_ready);
      if (m_phase && m_pend_rom) m_rom = 1;
      else if (rom_ack) m_rom = 0;
      if (m_racc) begin
        m_rsp_v = 1;
        m_rsp_d = {m_cfg[rd_dw*4+3], m_cfg[rd_dw*4+2], m_cfg[rd_dw*4+1], m_cfg[rd_dw*4]};
      end else if (rsp_ready) m_rsp_v = 0;
      if (m_phase) begin
        if (m_pend_bar >= 0)
          for (int k = 0; k < 4; k++)
            m_cfg[16 + 4*m_pend_bar + k] &= m_mask(m_pend_bar) >> (8*k);
        m_phase = 0;
      end else if (m_wacc) begin
        m_len = 0; m_off = wr_dw * 4;
        for (int k = 3; k >= 0; k--) if (wr_be[k]) begin m_len++; m_off = wr_dw*4 + k; end
        for (int k = 0; k < 4; k++)
          if (wr_be[k] && !m_locked(wr_dw*4 + k))
            m_cfg[wr_dw*4 + k] = (wr_dw*4 + k == 15) ? 8'h00 : wr_data[8*k +: 8];
        m_pend_bar = (wr_dw >= 4 && wr_dw <= 9 && wr_be != 0) ? int'(wr_dw) - 4 : -1;
        m_pend_rom = (wr_dw == 12) && (wr_be != 0);
        m_phase = 1;
      end
    end
  end

  // per-cycle comparison away from the clock edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R10 wr_ready", 32'(wr_ready), 32'(!m_phase));
    chk("R11 rd_ready", 32'(rd_ready), 32'(!m_phase && !wr_valid && (!m_rsp_v || rsp_ready)));
    chk("R11 rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
    if (m_rsp_v) chk("R11 rsp_data", rsp_data, m_rsp_d);
    chk("R5 enables", 32'({mem_en, io_en}), 32'(m_cfg[4][1:0]));
    chk("R8 bar_upd", 32'(bar_upd), (m_phase && m_pend_bar >= 0) ? 32'(1 << m_pend_bar) : 32'h0);
    chk("R7 rom_upd", 32'(rom_upd), 32'(m_rom));
    chk("R9 cfg_upd", 32'(cfg_upd), 32'(m_phase));
    if (m_phase) chk("R9 cfg_upd_off/len", {cfg_upd_off, 5'(cfg_upd_len)}, {8'(m_off), 5'(m_len)});
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #2;
    wr_valid = 1; wr_dw = dw; wr_be = be; wr_data = d;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #2;
    wr_valid = 0;
  endtask

  task automatic rd(input logic [5:0] dw, output logic [31:0] d);
    @(posedge clk); #2;
    rd_valid = 1; rd_dw = dw;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #2;
    rd_valid = 0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
  endtask

  task automatic rd_chk(input logic [5:0] dw, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(dw, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset image
    chk("R1 reset wr_ready", 32'(wr_ready), 32'h1);
    rd_chk(0, 32'h0A55_C0DE, "R1 ids");
    rd_chk(2, 32'h0600_0002, "R1 class/rev");
    rd_chk(3, 32'h0, "R1 header type");
    rd_chk(4, 32'h0000_C001, "R1 io bar");
    rd_chk(5, 32'hFEB0_0008, "R1 prefetch mem bar");
    rd_chk(6, 32'hFEC0_0000, "R1 mem bar");
    rd_chk(7, 32'h0, "R1 unused bar");
    rd_chk(15, 32'h0000_0100, "R1 int pin");

    // R2 locked bytes
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd_chk(0, 32'h0A55_C0DE, "R2 ids locked");
    wr(15, 4'hF, 32'hFFFF_FFFF);
    rd_chk(15, 32'hFFFF_01FF, "R2 int pin locked");

    // R3 masking, R8/R9 pulses
    wr(4, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 bar0 pulse", 32'(bar_upd), 32'h1);
    chk("R9 off/len", {cfg_upd_off, 5'(cfg_upd_len)}, {8'h10, 5'd4});
    rd_chk(4, 32'hFFFF_FFE1, "R3 io mask");
    wr(5, 4'hF, 32'hFFFF_FFFF);
    rd_chk(5, 32'hFFFF_C00F, "R3 mem mask 4 pages");
    wr(6, 4'b0010, 32'h0000_AB00);
    @(negedge clk);
    chk("R8 bar2 pulse", 32'(bar_upd), 32'h4);
    chk("R9 partial off/len", {cfg_upd_off, 5'(cfg_upd_len)}, {8'h19, 5'd1});
    rd_chk(6, 32'hFEC0_A000, "R3 partial lane mem mask");

    // R4 unused bars
    wr(7, 4'hF, 32'hFFFF_FFFF);
    rd_chk(7, 32'h0, "R4 unused bar3");
    wr(9, 4'hF, 32'h1234_5678);
    rd_chk(9, 32'h0, "R4 unused bar5");

    // R5 command enables
    wr(1, 4'b0001, 32'h0000_0003);
    @(negedge clk);
    chk("R5 both enables", 32'({mem_en, io_en}), 32'h3);
    wr(1, 4'b0001, 32'h0000_0002);
    @(negedge clk);
    chk("R5 mem only", 32'({mem_en, io_en}), 32'h2);

    // R6 self-test byte
    wr(3, 4'b1000, 32'hFF00_0000);
    rd_chk(3, 32'h0, "R6 bist lane only");
    wr(3, 4'hF, 32'hFFFF_FFFF);
    rd_chk(3, 32'h0000_FFFF, "R6 bist with neighbours");

    // R7 rom flag
    wr(13, 4'hF, 32'h1);
    repeat (2) @(negedge clk);
    chk("R7 rom not set by dw13", 32'(rom_upd), 32'h0);
    wr(12, 4'b0100, 32'h00AA_0000);
    repeat (4) @(negedge clk);
    chk("R7 rom held", 32'(rom_upd), 32'h1);
    @(posedge clk); #2 rom_ack = 1;
    @(posedge clk); #2 rom_ack = 0;
    @(negedge clk);
    chk("R7 rom cleared", 32'(rom_upd), 32'h0);

    // R9 zero-length write
    wr(20, 4'h0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 empty write", {cfg_upd_off, 5'(cfg_upd_len), 3'(cfg_upd)}, {8'h50, 5'd0, 3'd1});

    // R10 write wins over a simultaneous read of the same BAR
    fork
      wr(5, 4'hF, 32'h1234_5678);
      begin rd(5, d); chk("R10 read after masked write", d, 32'h1234_4008); end
    join

    // R11 back-pressure on the response
    @(posedge clk); #2 rsp_ready = 0; rd_valid = 1; rd_dw = 0;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #2 rd_dw = 2;
    repeat (5) @(negedge clk);
    chk("R11 held valid", 32'(rsp_valid), 32'h1);
    chk("R11 held data", rsp_data, 32'h0A55_C0DE);
    chk("R11 second request blocked", 32'(rd_ready), 32'h0);
    @(posedge clk); #2 rsp_ready = 1;
    @(negedge clk);
    chk("R11 next request taken", 32'(rd_ready), 32'h1);
    @(posedge clk); #2 rd_valid = 0;
    @(negedge clk);
    chk("R11 second response", rsp_data, 32'h0600_0002);
    repeat (3) @(posedge clk);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule